// File: doc/BRIEF.md
# Mode-Configurable Distributed LUT RAM

This block is a small memory cell made of two 16-entry, 1-bit stores, called F and G. Each store has its own read address, and read data always follows that address combinationally. A static configuration picks how writes reach the stores. In asynchronous single-port mode a write is level-sensitive: while write enable is high, the addressed entry of each store takes its data bit. In synchronous single-port mode the address, data and write enable are captured on one clock edge, and the write lands just after that edge. In synchronous dual-port mode the pair acts as one 16x1 memory with a read/write port on the F address and a read-only port on the G address. Every write then goes to the same entry of both stores, addressed by F and carrying the F data bit.

The write edge polarity is a configuration bit shared by both stores. Reset loads both stores from the initial-contents parameters, which default to all zeros. Configuration may change only while reset is held.

Top module: `lutRamCell`

## Requirements
- R1: While `rst` is high, every entry i of F reads as bit i of `INIT_F` and every entry i of G reads as bit i of `INIT_G`, and no write is taken.
- R2: `doutF` shows the F entry at `addrF` and `doutG` shows the G entry at `addrG`, changing within the same cycle as the address in every mode.
- R3: In both single-port modes F is written at `addrF` with `dinF`, and G is written at `addrG` with `dinG`, under the one shared `we`.
- R4: With `cfgSync`=0 and `cfgDual`=0, a write needs no clock. While `we` is high, the addressed entries follow `dinF`/`dinG`, and the read outputs show the new data at once.
- R5: With `cfgSync`=1, `we`, addresses and data are captured on the active edge. Before that edge, a read of the target entry shows the old value. Just after the edge it shows the new value.
- R6: `cfgNegEdge`=0 makes the rising edge of `clk` the active write edge, and `cfgNegEdge`=1 makes it the falling edge, for both stores together.
- R7: With `cfgDual`=1, a write stores `dinF` at entry `addrF` in both F and G.
- R8: With `cfgDual`=1, `addrG` never selects a write target and `dinG` has no effect on any entry.
- R9: With `cfgDual`=1, writes are synchronous whatever the value of `cfgSync`.
- R10: When `we` is low at the write point, no entry of either store changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for synchronous writes |
| rst | input | 1 | Active-high reset; loads the initial contents |
| cfgSync | input | 1 | 1 = edge-triggered write, 0 = level-sensitive write |
| cfgDual | input | 1 | 1 = dual-port (both stores written via the F address) |
| cfgNegEdge | input | 1 | 1 = falling edge is the active write edge |
| we | input | 1 | Write enable |
| addrF | input | ADDR_W | F read address and write address |
| addrG | input | ADDR_W | G read address; write address in single-port modes only |
| dinF | input | 1 | F write data; the data for both stores in dual-port mode |
| dinG | input | 1 | G write data in single-port modes |
| doutF | output | 1 | Combinational read of F at `addrF` |
| doutG | output | 1 | Combinational read of G at `addrG` |

## Verification
The bench builds the cell with `ADDR_W`=4 and with nonzero, asymmetric initial patterns for F and G. This makes the reset contents of every entry visible and lets the bench tell the two stores apart on read. It runs a separate reset-bounded phase for each of five configurations: asynchronous, synchronous on the rising edge, synchronous on the falling edge, dual-port, and dual-port with the synchronous bit cleared. Read addresses land often on the entry just written, so that old-before-edge and new-after-edge values and the dual-port mirror into G can be observed directly.

// File: rtl/lutRamPkg.sv
`timescale 1ns/1ps
package lutRamPkg;

  typedef enum logic [1:0] {
    MODE_ASYNC_SP = 2'd0,
    MODE_SYNC_SP  = 2'd1,
    MODE_SYNC_DP  = 2'd2
  } lutMode_e;

  typedef struct packed {
    logic wrF;
    logic wrG;
  } lutStrobe_t;

endpackage

// File: rtl/lutRamCtrl.sv
`timescale 1ns/1ps
module lutRamCtrl
  import lutRamPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgSync,
  input  logic              cfgDual,
  input  logic              cfgNegEdge,
  input  logic              we,
  input  logic [ADDR_W-1:0] addrF,
  input  logic [ADDR_W-1:0] addrG,
  input  logic              dinF,
  input  logic              dinG,
  output lutStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddrF,
  output logic [ADDR_W-1:0] wrAddrG,
  output logic              wrDataF,
  output logic              wrDataG
);

  lutMode_e mode;
  logic wrClk;
  logic capWe;
  logic [ADDR_W-1:0] capAddrF, capAddrG;
  logic capDinF, capDinG;
  logic pulse;

  // dual-port overrides the async setting
  always_comb begin
    if (cfgDual)      mode = MODE_SYNC_DP;
    else if (cfgSync) mode = MODE_SYNC_SP;
    else              mode = MODE_ASYNC_SP;
  end

  // one polarity bit serves both stores
  assign wrClk = clk ^ cfgNegEdge;

  always_ff @(posedge wrClk or posedge rst) begin
    if (rst) begin
      capWe    <= 1'b0;
      capAddrF <= '0;
      capAddrG <= '0;
      capDinF  <= 1'b0;
      capDinG  <= 1'b0;
    end else begin
      capWe    <= we;
      capAddrF <= addrF;
      capAddrG <= addrG;
      capDinF  <= dinF;
      capDinG  <= dinG;
    end
  end

  // write window: the phase that follows the active edge
  assign pulse = capWe & wrClk;

  always_comb begin
    strobe  = '0;
    wrAddrF = capAddrF;
    wrAddrG = capAddrG;
    wrDataF = capDinF;
    wrDataG = capDinG;
    case (mode)
      MODE_ASYNC_SP: begin
        strobe.wrF = we & ~rst;
        strobe.wrG = we & ~rst;
        wrAddrF    = addrF;
        wrAddrG    = addrG;
        wrDataF    = dinF;
        wrDataG    = dinG;
      end
      MODE_SYNC_SP: begin
        strobe.wrF = pulse;
        strobe.wrG = pulse;
      end
      MODE_SYNC_DP: begin
        strobe.wrF = pulse;
        strobe.wrG = pulse;
        wrAddrG    = capAddrF;
        wrDataG    = capDinF;
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/lutRamStore.sv
`timescale 1ns/1ps
module lutRamStore #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W,
  parameter logic [DEPTH-1:0] INIT = '0
) (
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdData
);

  logic [DEPTH-1:0] cells;

  for (genvar i = 0; i < DEPTH; i++) begin : gCell
    logic cellQ;
    logic hit;
    assign hit = wrEn && (wrAddr == ADDR_W'(i));
    always_latch begin
      if (rst)      cellQ <= INIT[i];
      else if (hit) cellQ <= wrData;
    end
    assign cells[i] = cellQ;
  end

  assign rdData = cells[rdAddr];

endmodule

// File: rtl/lutRamCell.sv
`timescale 1ns/1ps
module lutRamCell
  import lutRamPkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W,
  parameter logic [DEPTH-1:0] INIT_F = '0,
  parameter logic [DEPTH-1:0] INIT_G = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgSync,
  input  logic              cfgDual,
  input  logic              cfgNegEdge,
  input  logic              we,
  input  logic [ADDR_W-1:0] addrF,
  input  logic [ADDR_W-1:0] addrG,
  input  logic              dinF,
  input  logic              dinG,
  output logic              doutF,
  output logic              doutG
);

  lutStrobe_t strobe;
  logic [ADDR_W-1:0] wrAddrF, wrAddrG;
  logic wrDataF, wrDataG;

  lutRamCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rst(rst), .cfgSync(cfgSync), .cfgDual(cfgDual),
    .cfgNegEdge(cfgNegEdge), .we(we), .addrF(addrF), .addrG(addrG),
    .dinF(dinF), .dinG(dinG), .strobe(strobe),
    .wrAddrF(wrAddrF), .wrAddrG(wrAddrG),
    .wrDataF(wrDataF), .wrDataG(wrDataG)
  );

  lutRamStore #(.ADDR_W(ADDR_W), .INIT(INIT_F)) uMemF (
    .rst(rst), .wrEn(strobe.wrF), .wrAddr(wrAddrF), .wrData(wrDataF),
    .rdAddr(addrF), .rdData(doutF)
  );

  lutRamStore #(.ADDR_W(ADDR_W), .INIT(INIT_G)) uMemG (
    .rst(rst), .wrEn(strobe.wrG), .wrAddr(wrAddrG), .wrData(wrDataG),
    .rdAddr(addrG), .rdData(doutG)
  );

endmodule

// File: rtl/lutRamCellChk.sv
`timescale 1ns/1ps
module lutRamCellChk #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W,
  parameter logic [DEPTH-1:0] INIT_F = '0,
  parameter logic [DEPTH-1:0] INIT_G = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              cfgSync,
  input logic              cfgDual,
  input logic              cfgNegEdge,
  input logic              we,
  input logic [ADDR_W-1:0] addrF,
  input logic [ADDR_W-1:0] addrG,
  input logic              dinF,
  input logic              dinG,
  input logic              doutF,
  input logic              doutG
);

  logic wrClk;
  logic syncEff;
  logic armed;

  assign wrClk   = clk ^ cfgNegEdge;
  assign syncEff = cfgSync | cfgDual;

  always_ff @(posedge wrClk or posedge rst) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_RESET_INIT: assert property (@(negedge wrClk)
    rst |-> (doutF == INIT_F[addrF]) && (doutG == INIT_G[addrG])); // R1

  AST_ASYNC_TRANSPARENT: assert property (@(negedge wrClk) disable iff (rst)
    (!syncEff && we) |-> (doutF == dinF) && (doutG == dinG)); // R4

  AST_SYNC_WRITE: assert property (@(posedge wrClk) disable iff (rst)
    (armed && $past(we && syncEff && !cfgDual) && addrF == $past(addrF))
      |-> doutF == $past(dinF)); // R5

  AST_DUAL_MIRROR: assert property (@(posedge wrClk) disable iff (rst)
    (armed && $past(we && cfgDual) && addrG == $past(addrF))
      |-> doutG == $past(dinF)); // R7

  AST_NO_WRITE_HOLD: assert property (@(posedge wrClk) disable iff (rst)
    (armed && syncEff && $past(!we) && $stable(addrF)) |-> $stable(doutF)); // R10

endmodule

bind lutRamCell lutRamCellChk #(
  .ADDR_W(ADDR_W), .INIT_F(INIT_F), .INIT_G(INIT_G)
) uChk (
  .clk(clk), .rst(rst), .cfgSync(cfgSync), .cfgDual(cfgDual),
  .cfgNegEdge(cfgNegEdge), .we(we), .addrF(addrF), .addrG(addrG),
  .dinF(dinF), .dinG(dinG), .doutF(doutF), .doutG(doutG)
);

// File: tb/sim_lutRamCell.sv
`timescale 1ns/1ps
module sim_lutRamCell;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam logic [DEPTH-1:0] IF_PAT = 16'hA5C3;
  localparam logic [DEPTH-1:0] IG_PAT = 16'h3C96;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgSync = 1'b0, cfgDual = 1'b0, cfgNegEdge = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] addrF = '0, addrG = '0;
  logic dinF = 1'b0, dinG = 1'b0;
  wire  doutF, doutG;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;
  bit refF [DEPTH];
  bit refG [DEPTH];
  string phaseTag = "R3";

  always #4 clk = ~clk;

  lutRamCell #(.ADDR_W(AW), .INIT_F(IF_PAT), .INIT_G(IG_PAT)) u0 (
    .clk(clk), .rst(rst), .cfgSync(cfgSync), .cfgDual(cfgDual),
    .cfgNegEdge(cfgNegEdge), .we(we), .addrF(addrF), .addrG(addrG),
    .dinF(dinF), .dinG(dinG), .doutF(doutF), .doutG(doutG)
  );

  task automatic check(string tag, bit expF, bit expG);
    vecs++;
    if (doutF !== expF || doutG !== expG) begin
      errs++;
      $display("FAIL %s at %0t: doutF=%b doutG=%b expected doutF=%b doutG=%b",
               tag, $time, doutF, doutG, expF, expG);
    end
  endtask

  task automatic activeEdge();
    if (cfgNegEdge) @(negedge clk);
    else            @(posedge clk);
  endtask

  // enter a configuration under reset, check R1 contents, release
  task automatic resetInto(bit s, bit d, bit n);
    rst = 1'b1;
    we  = 1'b0;
    #2;
    cfgSync = s; cfgDual = d; cfgNegEdge = n;
    repeat (2) @(posedge clk);
    for (int a = 0; a < DEPTH; a++) begin
      refF[a] = IF_PAT[a];
      refG[a] = IG_PAT[a];
    end
    for (int a = 0; a < DEPTH; a++) begin
      #0.2 addrF = AW'(a); addrG = AW'(DEPTH - 1 - a);
      #0.2 check("R1", IF_PAT[a], IG_PAT[DEPTH - 1 - a]);
    end
    @(posedge clk);
    #2 rst = 1'b0;
    activeEdge();
    #1;
  endtask

  // one write cycle; enters and leaves one unit after the active edge
  task automatic step(bit w, logic [AW-1:0] aF, logic [AW-1:0] aG, bit dF, bit dG);
    bit isSync = cfgSync || cfgDual;
    string preTag;
    string postTag;
    #1 we = 1'b0;
    #0.5 addrF = aF; addrG = aG; dinF = dF; dinG = dG;
    #0.5 we = w;
    if (w && !isSync) begin
      refF[aF] = dF;
      refG[aG] = dG;
    end
    preTag = !w ? "R10" : (isSync ? "R5" : "R4");
    #4 check(preTag, refF[addrF], refG[addrG]);
    activeEdge();
    if (w && isSync) begin
      if (cfgDual) begin
        refF[aF] = dF;
        refG[aF] = dF;
      end else begin
        refF[aF] = dF;
        refG[aG] = dG;
      end
    end
    if (!w)                      postTag = "R10";
    else if (cfgDual && dF != dG) postTag = "R8";
    else                         postTag = phaseTag;
    #1 check(postTag, refF[addrF], refG[addrG]);
  endtask

  // R2: reads follow the address within a cycle
  task automatic readSweep();
    #1 we = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      #0.2 addrF = AW'(a); addrG = AW'(a ^ 5);
      #0.2 check("R2", refF[a], refG[a ^ 5]);
    end
    activeEdge();
    #1;
  endtask

  task automatic runPhase(string tag, bit s, bit d, bit n, int nSteps);
    phaseTag = tag;
    resetInto(s, d, n);
    for (int k = 0; k < nSteps; k++) begin
      logic [AW-1:0] aF = AW'($urandom_range(0, DEPTH - 1));
      logic [AW-1:0] aG = ($urandom_range(0, 2) == 0) ? aF : AW'($urandom_range(0, DEPTH - 1));
      bit w = ($urandom_range(0, 3) != 0);
      step(w, aF, aG, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    readSweep();
  endtask

  initial begin
    runPhase("R4", 1'b0, 1'b0, 1'b0, 120); // async single-port, R3 addressing
    runPhase("R3", 1'b1, 1'b0, 1'b0, 120); // sync single-port, rising edge
    runPhase("R6", 1'b1, 1'b0, 1'b1, 120); // sync single-port, falling edge
    runPhase("R7", 1'b1, 1'b1, 1'b0, 120); // dual-port
    runPhase("R9", 1'b0, 1'b1, 1'b1, 120); // dual-port, async bit ignored
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule